// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

A small, synthesizable model of a single-clock burst SRAM whose reads flow through. Address, write data, lane controls, selects and strobes are captured on the rising clock edge. The read word follows the registered address within the same cycle, so it appears shortly after the edge that loaded that address. Two active-low strobes open a burst: one for a processor and one for a cache controller. After that, an active-low step input moves a 2-bit sequence counter. The counter is preloaded from the two low address bits and runs in either linear or interleaved order. Writes are byte-granular, and a whole-word write input overrides the per-lane controls.

The block has a single cycle-state machine with three states. `ST_IDLE` means deselected. `ST_READ` means the current cycle is a read. `ST_WRITE` means the current cycle wrote the array. The transitions are:
- *start-read*: a processor strobe, or a controller strobe with no write request, taken while the chip is selected. It goes to `ST_READ`.
- *start-write*: a controller strobe with a write request while the chip is selected. It goes to `ST_WRITE`.
- *deselect*: any accepted strobe while the chip is not selected. It goes to `ST_IDLE`.
- *continue*: no strobe while in `ST_READ` or `ST_WRITE`. The machine moves to `ST_WRITE` or `ST_READ` depending on the lane controls, and the counter steps only when the step input is low.
- *stay-idle*: no strobe while in `ST_IDLE`.

The data bus is split into an input word, an output word and a drive-enable output. The enable controls an external shared-bus pad.

Top module: `sbsram_core`

## Requirements
- R1: After reset the state is `ST_IDLE` and `rdata_drive_o` is low.
- R2: Inputs take effect only at a rising edge. A change of `addr_i` with no strobe does not change `rdata_o` at the next edge.
- R3: With the chip selected, a low `strt_ctl_n` with no write request starts a burst at `addr_i`. From that edge on, `rdata_o` shows the word at that address and `rdata_drive_o` is high (with `rd_en_n` low).
- R4: A low `strt_cpu_n` starts a read burst only while `sel_a_n` is low. While `sel_a_n` is high it is ignored, and the running burst keeps its address.
- R5: A burst opened by `strt_cpu_n` is a read. `wall_n`, `lane_en_n` and `lane_n` write nothing in that cycle.
- R6: With `seq_sel` low at burst start, the low two address bits run start, start+1, start+2, start+3 modulo 4, one step per cycle with `step_n` low. After the fourth step they wrap to start.
- R7: With `seq_sel` high at burst start, the low two address bits are the start value XOR a count that runs 0,1,2,3.
- R8: In a burst cycle with no strobe and `step_n` high, the address holds.
- R9: A low `wall_n` in a write-capable cycle writes every lane of the addressed word.
- R10: With `wall_n` high, a write happens only if `lane_en_n` is low, and only into the lanes whose bit of `lane_n` is low. Lane k is bits 8k+7..8k. If `lane_en_n` is high the cycle is a read.
- R11: A strobe taken while any of `sel_a_n` high, `sel_b` low or `sel_c_n` high holds deselects the block in that one cycle. Nothing is written, and `rdata_drive_o` is low after that edge.
- R12: `rdata_drive_o` is high only when `rd_en_n` is low and the current cycle is a read. It follows `rd_en_n` without a clock edge.
- R13: When both strobes are low and `sel_a_n` is low, the processor strobe wins. The cycle is a read and nothing is written.
- R14: In a continued burst cycle, write data lands at the stepped address. A write cycle that starts a burst writes at the start address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| addr_i | input | AW | Word address; low two bits seed the sequence counter |
| strt_cpu_n | input | 1 | Processor burst-start strobe, active low |
| strt_ctl_n | input | 1 | Controller burst-start strobe, active low |
| step_n | input | 1 | Advance the sequence counter, active low |
| seq_sel | input | 1 | Burst order at start: 0 linear, 1 interleaved |
| sel_a_n | input | 1 | Chip select A, active low; also gates the processor strobe |
| sel_b | input | 1 | Chip select B, active high |
| sel_c_n | input | 1 | Chip select C, active low |
| wall_n | input | 1 | Whole-word write, active low |
| lane_en_n | input | 1 | Per-lane write enable, active low |
| lane_n | input | LANES | Per-lane write selects, active low |
| rd_en_n | input | 1 | Asynchronous output enable, active low |
| wdata_i | input | LANES*LW | Write data |
| rdata_o | output | LANES*LW | Flow-through read data |
| rdata_drive_o | output | 1 | Drive enable for the shared data bus |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a burst start and a write request: the processor strobe is driven together with the whole-word write, and separately together with the controller strobe. The second pair is a sequence step and a lane write: a controller-started burst keeps writing through stepped cycles with different lane masks. A bench-side word array models the memory, and each collision is judged by reading the affected addresses back through fresh bursts and comparing them with that array. The bench also sweeps every start offset in both burst orders across all upper address groups, and computes each expected address arithmetically.

// File: rtl/sbsram_pkg.sv
`timescale 1ns/1ps
package sbsram_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } cyc_state_e;

    function automatic logic [1:0] seq_lo(input logic [1:0] seed,
                                          input logic [1:0] cnt,
                                          input logic       xor_order);
        return xor_order ? (seed ^ cnt) : (seed + cnt);
    endfunction

endpackage

// File: rtl/burst_seq_gen.sv
`timescale 1ns/1ps
module burst_seq_gen
    import sbsram_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic       step_i,
    input  logic [1:0] seed_i,
    input  logic       order_i,
    output logic [1:0] lo_q_o,
    output logic [1:0] lo_nxt_o
);
    logic [1:0] seed_q, seed_d;
    logic [1:0] cnt_q,  cnt_d;
    logic       ord_q,  ord_d;

    always_comb begin
        seed_d = seed_q;
        cnt_d  = cnt_q;
        ord_d  = ord_q;
        if (load_i) begin
            seed_d = seed_i;
            cnt_d  = 2'd0;
            ord_d  = order_i;
        end else if (step_i) begin
            cnt_d  = cnt_q + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seed_q <= 2'd0;
            cnt_q  <= 2'd0;
            ord_q  <= 1'b0;
        end else begin
            seed_q <= seed_d;
            cnt_q  <= cnt_d;
            ord_q  <= ord_d;
        end
    end

    assign lo_q_o   = seq_lo(seed_q, cnt_q, ord_q);
    assign lo_nxt_o = seq_lo(seed_d, cnt_d, ord_d);

    // R6: linear order advances the low bits by one per step
    a_r6_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !ord_q) |=> (lo_q_o == $past(lo_q_o) + 2'd1));

    // R7: interleaved order advances the XOR distance from the seed by one
    a_r7_xor_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && ord_q) |=> ((lo_q_o ^ seed_q) == (($past(lo_q_o) ^ $past(seed_q)) + 2'd1)));
endmodule

// File: rtl/lane_write_dec.sv
`timescale 1ns/1ps
module lane_write_dec #(
    parameter int LANES = 4
) (
    input  logic             allow_i,
    input  logic             wall_n_i,
    input  logic             lane_en_n_i,
    input  logic [LANES-1:0] lane_n_i,
    output logic [LANES-1:0] req_o,
    output logic [LANES-1:0] we_o
);
    always_comb begin
        if (!wall_n_i)
            req_o = '1;
        else if (!lane_en_n_i)
            req_o = ~lane_n_i;
        else
            req_o = '0;
    end

    assign we_o = allow_i ? req_o : '0;
endmodule

// File: rtl/sram_lane_array.sv
`timescale 1ns/1ps
module sram_lane_array #(
    parameter int AW    = 6,
    parameter int LANES = 4,
    parameter int LW    = 8
) (
    input  logic                clk,
    input  logic [LANES-1:0]    we_i,
    input  logic [AW-1:0]       waddr_i,
    input  logic [LANES*LW-1:0] wdata_i,
    input  logic [AW-1:0]       raddr_i,
    output logic [LANES*LW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LW-1:0] cells [DEPTH];
        always_ff @(posedge clk) begin
            if (we_i[l]) cells[waddr_i] <= wdata_i[l*LW +: LW];
        end
        assign rdata_o[l*LW +: LW] = cells[raddr_i];
    end
endmodule

// File: rtl/sbsram_core.sv
`timescale 1ns/1ps
module sbsram_core
    import sbsram_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 4,
    parameter int LW    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       addr_i,
    input  logic                strt_cpu_n,
    input  logic                strt_ctl_n,
    input  logic                step_n,
    input  logic                seq_sel,
    input  logic                sel_a_n,
    input  logic                sel_b,
    input  logic                sel_c_n,
    input  logic                wall_n,
    input  logic                lane_en_n,
    input  logic [LANES-1:0]    lane_n,
    input  logic                rd_en_n,
    input  logic [LANES*LW-1:0] wdata_i,
    output logic [LANES*LW-1:0] rdata_o,
    output logic                rdata_drive_o
);
    localparam int HIW = AW - 2;

    cyc_state_e st_q, st_d;
    logic [HIW-1:0]   hi_q;
    logic             selected, cpu_go, ctl_go, start_go;
    logic             load, step;
    logic [1:0]       lo_q, lo_nxt;
    logic [LANES-1:0] lane_req, lane_we;
    logic [AW-1:0]    waddr, raddr;
    logic [LANES*LW-1:0] arr_rdata;

    assign selected = !sel_a_n && sel_b && !sel_c_n;
    assign cpu_go   = !strt_cpu_n && !sel_a_n;
    assign ctl_go   = !strt_ctl_n && !cpu_go;
    assign start_go = cpu_go || ctl_go;
    assign load     = start_go && selected;
    assign step     = !start_go && (st_q != ST_IDLE) && !step_n;

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (start_go) begin
            if (!selected)   st_d = ST_IDLE;
            else if (cpu_go) st_d = ST_READ;
            else             st_d = (|lane_req) ? ST_WRITE : ST_READ;
        end else begin
            unique case (st_q)
                ST_IDLE:           st_d = ST_IDLE;
                ST_READ, ST_WRITE: st_d = (|lane_req) ? ST_WRITE : ST_READ;
                default:           st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            hi_q <= '0;
        end else begin
            st_q <= st_d;
            if (load) hi_q <= addr_i[AW-1:2];
        end
    end

    burst_seq_gen u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .step_i   (step),
        .seed_i   (addr_i[1:0]),
        .order_i  (seq_sel),
        .lo_q_o   (lo_q),
        .lo_nxt_o (lo_nxt)
    );

    lane_write_dec #(.LANES(LANES)) u_dec (
        .allow_i     (st_d == ST_WRITE),
        .wall_n_i    (wall_n),
        .lane_en_n_i (lane_en_n),
        .lane_n_i    (lane_n),
        .req_o       (lane_req),
        .we_o        (lane_we)
    );

    assign waddr = {(load ? addr_i[AW-1:2] : hi_q), lo_nxt};
    assign raddr = {hi_q, lo_q};

    sram_lane_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_arr (
        .clk     (clk),
        .we_i    (lane_we),
        .waddr_i (waddr),
        .wdata_i (wdata_i),
        .raddr_i (raddr),
        .rdata_o (arr_rdata)
    );

    // output process
    always_comb begin
        rdata_o       = arr_rdata;
        rdata_drive_o = (st_q == ST_READ) && !rd_en_n;
    end

    // R11: a strobe while deselected leaves the bus undriven after the edge
    a_r11_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (start_go && !selected) |=> !rdata_drive_o);

    // R5: a processor-started cycle is a read
    a_r5_cpu_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_go && selected) |=> (st_q == ST_READ));

    // R8: without step or strobe the burst address holds
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q != ST_IDLE) && !start_go && step_n) |=> $stable(raddr));

    // R12: bus never driven with the output enable high
    a_r12_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_n |-> !rdata_drive_o);

    // R10: no write without a whole-word or lane enable
    a_r10_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (wall_n && lane_en_n) |-> (lane_we == '0));
endmodule

// File: tb/sbsram_core_tb_top.sv
`timescale 1ns/1ps
module sbsram_core_tb_top;
    localparam int AW = 6, LANES = 4, LW = 8, DW = LANES*LW, DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n;
    logic [AW-1:0] addr_i;
    logic strt_cpu_n, strt_ctl_n, step_n, seq_sel;
    logic sel_a_n, sel_b, sel_c_n, wall_n, lane_en_n, rd_en_n;
    logic [LANES-1:0] lane_n;
    logic [DW-1:0] wdata_i, rdata_o;
    logic rdata_drive_o;

    sbsram_core #(.AW(AW), .LANES(LANES), .LW(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .strt_cpu_n(strt_cpu_n),
        .strt_ctl_n(strt_ctl_n), .step_n(step_n), .seq_sel(seq_sel),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .wall_n(wall_n),
        .lane_en_n(lane_en_n), .lane_n(lane_n), .rd_en_n(rd_en_n),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .rdata_drive_o(rdata_drive_o)
    );

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;
    logic [DW-1:0] ref_mem [DEPTH];

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] seq_addr(input logic [AW-1:0] s, input int i, input bit il);
        logic [1:0] k;
        k = 2'(i);
        return il ? {s[AW-1:2], s[1:0] ^ k} : {s[AW-1:2], s[1:0] + k};
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                            input logic [LANES-1:0] m);
        logic [DW-1:0] r;
        r = old;
        for (int l = 0; l < LANES; l++) if (m[l]) r[l*LW +: LW] = nw[l*LW +: LW];
        return r;
    endfunction

    function automatic logic [DW-1:0] pat(input int a);
        logic [7:0] b;
        b = 8'(a);
        return {b + 8'h10, ~b, b ^ 8'h5A, b + 8'h80};
    endfunction

    task automatic quiet();
        strt_cpu_n = 1; strt_ctl_n = 1; step_n = 1; wall_n = 1; lane_en_n = 1;
        lane_n = '1; sel_a_n = 0; sel_b = 1; sel_c_n = 0; rd_en_n = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] base;
        rst_n = 0; addr_i = '0; seq_sel = 0; wdata_i = '0;
        quiet();
        repeat (3) tick();
        chk("R1 reset drive", DW'(rdata_drive_o), '0);
        rst_n = 1;
        tick();
        chk("R1 idle after reset", DW'(rdata_drive_o), '0);

        // fill every word with whole-word writes (R9, R14 start address)
        for (int a = 0; a < DEPTH; a++) begin
            quiet();
            addr_i = AW'(a); strt_ctl_n = 0; wall_n = 0; wdata_i = pat(a);
            tick();
            ref_mem[a] = pat(a);
            if (a == 0) chk("R12 no drive in write", DW'(rdata_drive_o), '0);
        end
        quiet();

        // sweep all groups, start offsets and both orders
        for (int m = 0; m < 2; m++) begin
            for (int g = 0; g < DEPTH/4; g++) begin
                for (int lo = 0; lo < 4; lo++) begin
                    base = AW'(g*4 + lo);
                    quiet(); seq_sel = m[0]; addr_i = base; strt_cpu_n = 0;
                    tick();
                    strt_cpu_n = 1;
                    chk("R4 cpu start data", rdata_o, ref_mem[base]);
                    chk("R3 drive on read", DW'(rdata_drive_o), DW'(1));
                    step_n = 0;
                    for (int i = 1; i < 4; i++) begin
                        tick();
                        chk(m ? "R7 interleaved step" : "R6 linear step", rdata_o,
                            ref_mem[seq_addr(base, i, m[0])]);
                    end
                    step_n = 1; addr_i = ~base; seq_sel = ~m[0];
                    tick();
                    chk("R8 R2 hold", rdata_o, ref_mem[seq_addr(base, 3, m[0])]);
                    step_n = 0;
                    tick();
                    chk(m ? "R7 wrap" : "R6 wrap", rdata_o, ref_mem[base]);
                end
            end
        end
        quiet();

        // burst write with steps and changing lane masks, interleaved
        base = AW'(22); seq_sel = 1;
        addr_i = base; strt_ctl_n = 0; lane_en_n = 0; lane_n = 4'b1010; wdata_i = 32'h11223344;
        tick();
        ref_mem[seq_addr(base,0,1)] = merge(ref_mem[seq_addr(base,0,1)], 32'h11223344, 4'b0101);
        chk("R12 write cycle undriven", DW'(rdata_drive_o), '0);
        strt_ctl_n = 1; step_n = 0; lane_n = 4'b0111; wdata_i = 32'hAABBCCDD;
        tick();
        ref_mem[seq_addr(base,1,1)] = merge(ref_mem[seq_addr(base,1,1)], 32'hAABBCCDD, 4'b1000);
        wall_n = 0; lane_en_n = 1; lane_n = 4'b1111; wdata_i = 32'h55667788;
        tick();
        ref_mem[seq_addr(base,2,1)] = 32'h55667788;
        wall_n = 1; lane_en_n = 1; lane_n = 4'b0000; wdata_i = 32'hDEADBEEF;
        tick();
        chk("R10 lanes without enable read", rdata_o, ref_mem[seq_addr(base,3,1)]);
        chk("R10 read drive", DW'(rdata_drive_o), DW'(1));
        quiet(); seq_sel = 1; addr_i = base; strt_cpu_n = 0;
        tick();
        strt_cpu_n = 1; step_n = 0;
        chk("R14 R10 lane write start", rdata_o, ref_mem[seq_addr(base,0,1)]);
        tick();
        chk("R14 R10 stepped lane write", rdata_o, ref_mem[seq_addr(base,1,1)]);
        tick();
        chk("R9 R14 whole word", rdata_o, ref_mem[seq_addr(base,2,1)]);
        quiet(); seq_sel = 0;

        // processor strobe with write controls
        addr_i = 6'd9; strt_cpu_n = 0; wall_n = 0; wdata_i = '0;
        tick();
        chk("R5 cpu ignores write", rdata_o, ref_mem[9]);
        chk("R5 drive", DW'(rdata_drive_o), DW'(1));
        quiet();

        // both strobes: processor wins
        addr_i = 6'd10; strt_cpu_n = 0; strt_ctl_n = 0; wall_n = 0; wdata_i = '0;
        tick();
        chk("R13 both strobes read", rdata_o, ref_mem[10]);
        chk("R13 drive", DW'(rdata_drive_o), DW'(1));
        quiet();
        addr_i = 6'd10; strt_ctl_n = 0;
        tick();
        chk("R13 no write", rdata_o, ref_mem[10]);
        quiet();

        // processor strobe gated by select A
        addr_i = 6'd12; strt_cpu_n = 0;
        tick();
        quiet(); sel_a_n = 1; strt_cpu_n = 0; addr_i = 6'd40;
        tick();
        chk("R4 gated strobe ignored", rdata_o, ref_mem[12]);
        chk("R4 still driving", DW'(rdata_drive_o), DW'(1));
        quiet();

        // deselect by each select
        for (int k = 0; k < 3; k++) begin
            quiet();
            if (k == 0) sel_a_n = 1;
            if (k == 1) sel_b = 0;
            if (k == 2) sel_c_n = 1;
            addr_i = AW'(20 + k); strt_ctl_n = 0; wall_n = 0; wdata_i = '0;
            tick();
            chk("R11 deselect undriven", DW'(rdata_drive_o), '0);
            quiet(); addr_i = AW'(20 + k); strt_ctl_n = 0;
            tick();
            chk("R11 R3 no write while deselected", rdata_o, ref_mem[20 + k]);
        end
        quiet();

        // asynchronous output enable
        addr_i = 6'd33; strt_ctl_n = 0;
        tick();
        strt_ctl_n = 1;
        chk("R3 ctl read data", rdata_o, ref_mem[33]);
        rd_en_n = 1;
        #1;
        chk("R12 oe high", DW'(rdata_drive_o), '0);
        rd_en_n = 0;
        #1;
        chk("R12 oe low", DW'(rdata_drive_o), DW'(1));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule